// File: doc/BRIEF.md
# Key debounce and hold-time classifier

This block cleans up the eight push-button inputs of a voice recorder controller. Each raw, active-high key passes through a two-stage synchronizer and a per-key debounce counter. The debounce interval has two settings. The long interval is for keys pressed by hand. The short interval is for a host controller that drives the same pins. The result is a clean level per key and a one-cycle pulse on each debounced press.

Two keys are level keys: record and level-play. For these the downstream logic acts for as long as the clean level stays high. The other keys act on the press pulse. Forward, backward and reset also carry a hold-time classifier. A short hold yields a short event when the key is released. A long hold yields a long event as soon as the threshold is crossed, and that press then gives no short event. Hold time is measured in ticks from one shared prescaler.

Stop and edge-play are further qualified by the playback state. This gives a stop request or a skip request. Which one depends on whether the recorder runs in single-segment or multi-segment mode.

Top module: `key_conditioner`

## Requirements
- R1: While reset is asserted and directly after it, every output is 0.
- R2: In manual mode (`ctrl_mode`=0), `key_level[k]` takes a new raw value exactly DEB_MANUAL+2 cycles after `raw_keys[k]` changes, if the raw value holds that long. A raw pulse shorter than DEB_MANUAL cycles leaves the level unchanged.
- R3: In controller mode (`ctrl_mode`=1), the same rule applies with DEB_CTRL in place of DEB_MANUAL.
- R4: Key bit order is 0 record, 1 edge-play, 2 level-play, 3 forward, 4 backward, 5 stop, 6 erase, 7 reset. `key_rise[k]` pulses for one cycle in the cycle `key_level[k]` goes from 0 to 1. It never pulses on a release.
- R5: If forward is released before its hold reaches NAV_LONG_TICKS ticks, `fwd_short` pulses once, one cycle after `key_level[3]` falls. Backward does the same on `bwd_short`.
- R6: If forward stays held for NAV_LONG_TICKS ticks, `fwd_long` pulses once while the key is still held, and no short event follows on release. Backward does the same on `bwd_long`.
- R7: Reset uses RST_LONG_TICKS ticks with the same rules, on `rst_short` and `rst_long`.
- R8: `stop_req` pulses one cycle after a stop press, but only if `play_active` was high in the cycle of the press.
- R9: An edge-play press while `play_active` is high gives a pulse one cycle later. The pulse is on `stop_req` when `multi_seg`=0 and on `skip_req` when `multi_seg`=1. With `play_active` low, neither pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_mode | input | 1 | 1 selects the short controller debounce interval |
| multi_seg | input | 1 | 1 selects multi-segment behaviour of edge-play |
| play_active | input | 1 | Playback is in progress |
| raw_keys | input | 8 | Raw key inputs, bit order as in R4 |
| key_level | output | 8 | Debounced key levels |
| key_rise | output | 8 | One-cycle debounced press pulses |
| stop_req | output | 1 | Stop-playback request pulse |
| skip_req | output | 1 | Skip-to-next-segment request pulse |
| fwd_short | output | 1 | Forward short press (next segment) |
| fwd_long | output | 1 | Forward long press (last segment) |
| bwd_short | output | 1 | Backward short press (previous segment) |
| bwd_long | output | 1 | Backward long press (first segment) |
| rst_short | output | 1 | Reset short press (initialise) |
| rst_long | output | 1 | Reset long press (clear memory) |

## Verification
A raw edge driven before clock edge c+1 has a fixed latency. The level and the press pulse appear at cycle c+DEB+2. Stop and skip requests and short-press events appear at c+DEB+3. For each of these, the driver pushes an item with that exact cycle into the queue. Long events depend on where the shared prescaler stands when the press lands. Their items carry a window from (threshold-1) ticks to threshold ticks after the level rises, plus two cycles of slack. The monitor samples every pulse on the falling clock edge and matches it in order against the queue. Any pulse with no item waiting counts as a failure. This is how glitches, releases and unqualified stops are shown to produce nothing.

// File: rtl/key_conditioner.sv
module key_conditioner #(
  parameter int DEB_MANUAL     = 24576,
  parameter int DEB_CTRL       = 1459,
  parameter int TICK_DIV       = 7680,
  parameter int NAV_LONG_TICKS = 100,
  parameter int RST_LONG_TICKS = 200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctrl_mode,
  input  logic       multi_seg,
  input  logic       play_active,
  input  logic [7:0] raw_keys,
  output logic [7:0] key_level,
  output logic [7:0] key_rise,
  output logic       stop_req,
  output logic       skip_req,
  output logic       fwd_short,
  output logic       fwd_long,
  output logic       bwd_short,
  output logic       bwd_long,
  output logic       rst_short,
  output logic       rst_long
);
  localparam int NK   = 8;
  localparam int NH   = 3;
  localparam int DMAX = (DEB_MANUAL > DEB_CTRL) ? DEB_MANUAL : DEB_CTRL;
  localparam int DW   = $clog2(DMAX + 1);
  localparam int TW   = $clog2(TICK_DIV + 1);
  localparam int HMAX = (NAV_LONG_TICKS > RST_LONG_TICKS) ? NAV_LONG_TICKS : RST_LONG_TICKS;
  localparam int HW   = $clog2(HMAX + 1);
  localparam logic [DW-1:0] LIM_MAN  = DW'(DEB_MANUAL - 1);
  localparam logic [DW-1:0] LIM_CTL  = DW'(DEB_CTRL - 1);
  localparam logic [TW-1:0] TICK_TOP = TW'(TICK_DIV - 1);
  localparam logic [HW-1:0] NAV_TOP  = HW'(NAV_LONG_TICKS - 1);
  localparam logic [HW-1:0] RST_TOP  = HW'(RST_LONG_TICKS - 1);

  logic [NK-1:0] sync1, sync2, stable, rise_q;
  logic [DW-1:0] dcnt [NK];
  logic [TW-1:0] tcnt;
  logic [HW-1:0] hcnt [NH];
  logic [NH-1:0] held_q, done_q, short_q, long_q;
  logic          stop_q, skip_q;

  wire [DW-1:0] lim  = ctrl_mode ? LIM_CTL : LIM_MAN;
  wire          tick = (tcnt == TICK_TOP);
  wire [NH-1:0] hlev = {stable[7], stable[4], stable[3]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= raw_keys;
      sync2 <= sync1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      stable <= '0;
      rise_q <= '0;
      for (int k = 0; k < NK; k++) dcnt[k] <= '0;
    end else begin
      for (int k = 0; k < NK; k++) begin
        rise_q[k] <= 1'b0;
        if (sync2[k] == stable[k]) begin
          dcnt[k] <= '0;
        end else if (dcnt[k] >= lim) begin
          dcnt[k]   <= '0;
          stable[k] <= sync2[k];
          rise_q[k] <= sync2[k];
        end else begin
          dcnt[k] <= dcnt[k] + 1'b1;
        end
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) tcnt <= '0;
    else        tcnt <= tick ? '0 : tcnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      held_q  <= '0;
      done_q  <= '0;
      short_q <= '0;
      long_q  <= '0;
      for (int j = 0; j < NH; j++) hcnt[j] <= '0;
    end else begin
      for (int j = 0; j < NH; j++) begin
        held_q[j]  <= hlev[j];
        short_q[j] <= 1'b0;
        long_q[j]  <= 1'b0;
        if (!hlev[j]) begin
          if (held_q[j] && !done_q[j]) short_q[j] <= 1'b1;
          hcnt[j]   <= '0;
          done_q[j] <= 1'b0;
        end else if (tick && !done_q[j]) begin
          if (hcnt[j] == ((j == 2) ? RST_TOP : NAV_TOP)) begin
            long_q[j] <= 1'b1;
            done_q[j] <= 1'b1;
          end else begin
            hcnt[j] <= hcnt[j] + 1'b1;
          end
        end
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      stop_q <= 1'b0;
      skip_q <= 1'b0;
    end else begin
      stop_q <= play_active & (rise_q[5] | (rise_q[1] & ~multi_seg));
      skip_q <= play_active & multi_seg & rise_q[1];
    end

  assign key_level = stable;
  assign key_rise  = rise_q;
  assign stop_req  = stop_q;
  assign skip_req  = skip_q;
  assign fwd_short = short_q[0];
  assign bwd_short = short_q[1];
  assign rst_short = short_q[2];
  assign fwd_long  = long_q[0];
  assign bwd_long  = long_q[1];
  assign rst_long  = long_q[2];
endmodule

// File: rtl/key_conditioner_chk.sv
module key_conditioner_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       multi_seg,
  input logic       play_active,
  input logic [7:0] key_level,
  input logic [7:0] key_rise,
  input logic       stop_req,
  input logic       skip_req,
  input logic       fwd_short,
  input logic       fwd_long,
  input logic       bwd_long,
  input logic       rst_long
);
  AST_RISE_WITH_LEVEL: assert property (@(posedge clk) disable iff (!rst_n) (key_rise & ~key_level) == 8'h00); // R4
  AST_RISE_ONLY_NEW:   assert property (@(posedge clk) disable iff (!rst_n) (key_rise & $past(key_level)) == 8'h00); // R4
  AST_SHORT_RELEASED:  assert property (@(posedge clk) disable iff (!rst_n) fwd_short |-> !key_level[3]); // R5
  AST_FWD_LONG_HELD:   assert property (@(posedge clk) disable iff (!rst_n) fwd_long |-> key_level[3]); // R6
  AST_BWD_LONG_HELD:   assert property (@(posedge clk) disable iff (!rst_n) bwd_long |-> key_level[4]); // R6
  AST_RST_LONG_HELD:   assert property (@(posedge clk) disable iff (!rst_n) rst_long |-> key_level[7]); // R7
  AST_STOP_PLAYING:    assert property (@(posedge clk) disable iff (!rst_n) stop_req |-> $past(play_active)); // R8
  AST_SKIP_MULTI:      assert property (@(posedge clk) disable iff (!rst_n) skip_req |-> $past(multi_seg && play_active && key_rise[1])); // R9
endmodule

bind key_conditioner key_conditioner_chk chk (.*);

// File: tb/key_conditioner_test.sv
`timescale 1ns/1ps
module key_conditioner_test;
  localparam int DM = 20, DC = 4, TD = 16, NAV = 5, RST = 10;

  logic clk = 0, rst_n = 0, ctrl_mode = 0, multi_seg = 0, play_active = 0;
  logic [7:0] raw_keys = '0;
  logic [7:0] key_level, key_rise;
  logic stop_req, skip_req, fwd_short, fwd_long, bwd_short, bwd_long, rst_short, rst_long;

  key_conditioner #(.DEB_MANUAL(DM), .DEB_CTRL(DC), .TICK_DIV(TD),
                    .NAV_LONG_TICKS(NAV), .RST_LONG_TICKS(RST)) uut (.*);

  always #2.5 clk = ~clk;

  typedef struct { int code; int lo; int hi; string req; } item_t;
  item_t q[$];
  int cyc = 0, tests = 0, fails = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic push(int code, int lo, int hi, string req);
    item_t it;
    it.code = code; it.lo = lo; it.hi = hi; it.req = req;
    q.push_back(it);
  endtask

  always @(negedge clk) if (rst_n) begin
    logic [15:0] ev;
    ev = {rst_long, rst_short, bwd_long, bwd_short, fwd_long, fwd_short, skip_req, stop_req, key_rise};
    for (int c = 0; c < 16; c++) if (ev[c]) begin
      tests++;
      if (q.size() == 0) begin
        fails++;
        $display("FAIL unexpected event: actual code %0d at cycle %0d, expected none", c, cyc);
      end else begin
        item_t it;
        it = q.pop_front();
        if (it.code != c || cyc < it.lo || cyc > it.hi) begin
          fails++;
          $display("FAIL %s: actual code %0d at cycle %0d, expected code %0d in [%0d,%0d]",
                   it.req, c, cyc, it.code, it.lo, it.hi);
        end
      end
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive key k to v; returns cycle at drive and debounce length in use
  task automatic drive(int k, bit v, output int c, output int d);
    @(negedge clk);
    raw_keys[k] = v;
    c = cyc;
    d = ctrl_mode ? DC : DM;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tap(int k, int hold, bit expect_req, int req_code, string req);
    int c, d;
    drive(k, 1, c, d);
    push(k, c + d + 2, c + d + 2, req);
    if (expect_req) push(req_code, c + d + 3, c + d + 3, req);
    idle(hold);
    drive(k, 0, c, d);
    idle(d + 6);
  endtask

  task automatic hold_key(int k, int hold, int thr, int scode, int lcode, string req);
    int c, d, r;
    drive(k, 1, c, d);
    r = c + d + 2;
    push(k, r, r, req);
    if (hold < (thr - 1) * TD) begin
      idle(hold);
      drive(k, 0, c, d);
      push(scode, c + d + 3, c + d + 3, req);
    end else begin
      push(lcode, r + (thr - 1) * TD, r + thr * TD + 2, req);
      idle(hold);
      drive(k, 0, c, d);
    end
    idle(d + 6);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: actual hung run, expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int c, d;
    idle(3);
    check({key_level, key_rise, stop_req, skip_req, fwd_short, fwd_long, bwd_short,
           bwd_long, rst_short, rst_long} == '0, "R1 reset", int'(key_level), 0);
    rst_n = 1;
    idle(3);
    check(key_level == 8'h00 && key_rise == 8'h00, "R1 after reset", int'(key_level), 0);

    // R2 manual debounce, record level held
    drive(0, 1, c, d);
    push(0, c + DM + 2, c + DM + 2, "R2");
    idle(DM + 1);
    check(key_level[0] == 1'b0, "R2 not yet", int'(key_level), 0);
    idle(1);
    check(key_level == 8'h01, "R2 record level", int'(key_level), 1);
    idle(30);
    check(key_level == 8'h01, "R2 level held", int'(key_level), 1);
    drive(0, 0, c, d);
    idle(DM + 3);
    check(key_level == 8'h00, "R4 release no pulse", int'(key_level), 0);

    // R2 glitch on erase
    drive(6, 1, c, d);
    idle(10);
    drive(6, 0, c, d);
    idle(DM + 6);
    check(key_level == 8'h00, "R2 glitch ignored", int'(key_level), 0);

    // R4 bit position for level-play
    tap(2, 30, 0, 0, "R4");
    check(key_level == 8'h00, "R4 level-play released", int'(key_level), 0);

    // R3 controller mode
    ctrl_mode = 1;
    drive(2, 1, c, d);
    push(2, c + DC + 2, c + DC + 2, "R3");
    idle(DC + 2);
    check(key_level == 8'h04, "R3 short debounce", int'(key_level), 4);
    drive(2, 0, c, d);
    idle(DC + 6);
    drive(6, 1, c, d);
    idle(DC - 2);
    drive(6, 0, c, d);
    idle(DC + 6);
    check(key_level == 8'h00, "R3 glitch ignored", int'(key_level), 0);

    // R8 stop
    tap(5, 10, 0, 8, "R8");
    play_active = 1;
    tap(5, 10, 1, 8, "R8");

    // R9 edge-play
    multi_seg = 0;
    tap(1, 10, 1, 8, "R9");
    multi_seg = 1;
    tap(1, 10, 1, 9, "R9");
    play_active = 0;
    tap(1, 10, 0, 9, "R9");

    // R5 / R6 forward and backward
    hold_key(3, 30, NAV, 10, 11, "R5");
    hold_key(3, 120, NAV, 10, 11, "R6");
    hold_key(4, 30, NAV, 12, 13, "R5");
    hold_key(4, 120, NAV, 12, 13, "R6");

    // R7 reset key
    hold_key(7, 60, RST, 14, 15, "R7");
    hold_key(7, 220, RST, 14, 15, "R7");

    // manual mode long press
    ctrl_mode = 0;
    hold_key(3, 130, NAV, 10, 11, "R6");

    idle(20);
    check(q.size() == 0, "R2 all events seen", q.size(), 0);
    check(key_level == 8'h00, "R4 final idle", int'(key_level), 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule